// File: doc/BRIEF.md
# Boot Address Remap Decoder

This block decodes the processor address bus of a small system into chip selects for a boot ROM, a RAM and a peripheral region. After a hard reset the system starts in boot mode. In this mode the ROM select ignores the upper address bits, so the 64 KB ROM appears across the whole map outside the peripheral window. Its first copy sits at address zero, which means the reset vector fetch returns valid code. The ROM also always answers at its permanent base of 0xE0000000.

The boot code jumps to the high ROM alias and then triggers a remap. After the remap, RAM occupies the low region starting at zero, so the trap vectors (including the fast-interrupt entry at 0x1C) can be written and then fetched from RAM. ROM is then fully decoded in its high window only, and any address that hits no region raises an error flag.

The remap is triggered by writing a control bit. A build parameter makes the first bus write after reset trigger the remap instead. Software reads a status bit through the same control port to confirm the swap.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset, bit 0 of `ctl_rdata` (the remap status) is 0, which means boot mode. All other bits of `ctl_rdata` always read 0.
- R2: In boot mode, a read at any address outside the peripheral window asserts `sel_rom`. This includes 0x00000000, 0x0000001C and 0x12345678.
- R3: A read in 0xE0000000–0xE000FFFF asserts `sel_rom`, both before and after the remap.
- R4: A control write (`ctl_wr`) with `ctl_wdata[0]`=1 sets the remap status from the next clock edge. A control write with `ctl_wdata[0]`=0 leaves it unchanged.
- R5: Once set, the remap status stays set until reset, including across later control writes of 0.
- R6: After the remap, reads and writes in 0x00000000–0x000FFFFF assert `sel_ram`. This includes the vector at 0x1C and the last word 0x000FFFFC.
- R7: After the remap, an access that hits no region asserts no select and asserts `map_err`. Examples are 0x12345678, 0xE0010000 and 0x00100000.
- R8: With `AUTO_TRIGGER`=0, a boot-mode write to the low region asserts no select, asserts `map_err` and does not change the remap status.
- R9: With `AUTO_TRIGGER`=1, the first bus write in boot mode sets the remap status from the next edge. That same write is decoded with the remapped map, so a write to 0x0 asserts `sel_ram` in its own cycle.
- R10: An access in 0x80000000–0x8000FFFF asserts `sel_periph` in both modes, for reads and for writes.
- R11: A write never asserts `sel_rom`. A write that would decode to ROM asserts `map_err` instead.
- R12: At most one of `sel_rom`, `sel_ram`, `sel_periph` and `map_err` is high at a time. With neither `bus_rd` nor `bus_wr` high, all four are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; enters boot mode |
| bus_addr | input | 32 | Processor byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 0 = 1 requests remap |
| ctl_rdata | output | 8 | Control read data; bit 0 = remap status |
| sel_rom | output | 1 | ROM chip select |
| sel_ram | output | 1 | RAM chip select |
| sel_periph | output | 1 | Peripheral chip select |
| map_err | output | 1 | Access hit no permitted region |

## Verification
The bench targets these corner cases:

- **Aliasing.** It probes vector 0x1C, a far-off address and the high ROM window in boot mode. A decoder that fully decodes ROM in boot mode would fail to select ROM at 0x1C.
- **Window edges after remap.** It probes the last RAM word, the first address past RAM and the first address past the ROM window. A decoder that kept the partial ROM decode after remap would select ROM where it must raise an error.
- **Boot-mode writes.** A write to zero in boot mode must go nowhere in the explicit build. In the automatic build, the same write must land in RAM in its own cycle and flip the status one edge later.
- **Sticky flag.** A flag that clears on a later zero write, or that ignores the data bit, shows up in the status readback.

// File: rtl/remap_pkg.sv
// Package: shared types for the boot remap decoder.
// Assumes: one decode target per cycle; NONE means no chip select.
package remap_pkg;
    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_ROM    = 2'd1,
        TGT_RAM    = 2'd2,
        TGT_PERIPH = 2'd3
    } target_e;
endpackage

// File: rtl/region_match.sv
// region_match: flags an address that falls in an aligned power-of-two window.
// Assumes: BASE is aligned to 2**WIN_BITS and WIN_BITS < ADDR_W.
module region_match #(
    parameter int          ADDR_W   = 32,
    parameter int          WIN_BITS = 16,
    parameter logic [31:0] BASE     = 32'h0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam logic [ADDR_W-1:0] BASE_W = BASE[ADDR_W-1:0];

    // compare only the bits above the window offset
    assign hit = (addr[ADDR_W-1:WIN_BITS] == BASE_W[ADDR_W-1:ADDR_W-TAG_W]);
endmodule

// File: rtl/remap_state.sv
// remap_state: the single sticky boot/remapped flag.
// Assumes: reset is synchronous and active low; the flag can only be set, never
// cleared, except by reset.
module remap_state #(
    parameter bit AUTO_TRIGGER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_req,
    input  logic bus_wr,
    output logic remapped
);
    logic auto_fire;

    // pick the trigger variant at build time
    generate
        if (AUTO_TRIGGER) begin : g_auto
            assign auto_fire = bus_wr;
        end else begin : g_manual
            assign auto_fire = 1'b0;
        end
    endgenerate

    // set once on a trigger, hold until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            remapped <= 1'b0;
        else if (ctl_req || auto_fire)
            remapped <= 1'b1;
    end
endmodule

// File: rtl/addr_decoder.sv
// addr_decoder: turns an access into a single target for the current map.
// Assumes: ROM is read-only; in boot mode ROM decode ignores the upper address bits.
// The peripheral window is always fully decoded.
module addr_decoder
    import remap_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] ROM_BASE    = 32'hE000_0000,
    parameter int          ROM_BITS    = 16,
    parameter logic [31:0] RAM_BASE    = 32'h0000_0000,
    parameter int          RAM_BITS    = 20,
    parameter logic [31:0] PERIPH_BASE = 32'h8000_0000,
    parameter int          PERIPH_BITS = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              final_map,
    output target_e           tgt,
    output logic              err
);
    logic rom_hit, ram_hit, per_hit, access;

    region_match #(.ADDR_W(ADDR_W), .WIN_BITS(ROM_BITS), .BASE(ROM_BASE))
        u_rom (.addr(addr), .hit(rom_hit));
    region_match #(.ADDR_W(ADDR_W), .WIN_BITS(RAM_BITS), .BASE(RAM_BASE))
        u_ram (.addr(addr), .hit(ram_hit));
    region_match #(.ADDR_W(ADDR_W), .WIN_BITS(PERIPH_BITS), .BASE(PERIPH_BASE))
        u_per (.addr(addr), .hit(per_hit));

    assign access = rd || wr;

    // choose one target by priority: peripheral, then per-mode memory decode
    always_comb begin
        tgt = TGT_NONE;
        if (access) begin
            if (per_hit)
                tgt = TGT_PERIPH;
            else if (final_map) begin
                if (ram_hit)
                    tgt = TGT_RAM;
                else if (rom_hit && !wr)
                    tgt = TGT_ROM;
            end else if (!wr)
                tgt = TGT_ROM;
        end
    end

    // an access that found no target is an error
    assign err = access && (tgt == TGT_NONE);
endmodule

// File: rtl/boot_remap_decoder.sv
// boot_remap_decoder: top level. Boot mode aliases ROM at zero; after a remap,
// RAM sits at zero and ROM only at its high window.
// Assumes: selects are combinational from the address and strobes. The remap
// status changes on the clock edge after the trigger.
module boot_remap_decoder
    import remap_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          CTL_W        = 8,
    parameter bit          AUTO_TRIGGER = 1'b0,
    parameter logic [31:0] ROM_BASE     = 32'hE000_0000,
    parameter int          ROM_BITS     = 16,
    parameter logic [31:0] RAM_BASE     = 32'h0000_0000,
    parameter int          RAM_BITS     = 20,
    parameter logic [31:0] PERIPH_BASE  = 32'h8000_0000,
    parameter int          PERIPH_BITS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_periph,
    output logic              map_err
);
    localparam int REMAP_BIT = 0;

    logic    remapped, final_map, ctl_req;
    target_e tgt;

    assign ctl_req = ctl_wr && ctl_wdata[REMAP_BIT];

    remap_state #(.AUTO_TRIGGER(AUTO_TRIGGER)) u_state (
        .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req),
        .bus_wr(bus_wr), .remapped(remapped)
    );

    // a triggering write in the automatic build already uses the final map
    assign final_map = remapped || (AUTO_TRIGGER && bus_wr);

    addr_decoder #(
        .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_BITS(ROM_BITS),
        .RAM_BASE(RAM_BASE), .RAM_BITS(RAM_BITS),
        .PERIPH_BASE(PERIPH_BASE), .PERIPH_BITS(PERIPH_BITS)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .final_map(final_map), .tgt(tgt), .err(map_err)
    );

    // fan the target out to one-hot chip selects
    assign sel_rom    = (tgt == TGT_ROM);
    assign sel_ram    = (tgt == TGT_RAM);
    assign sel_periph = (tgt == TGT_PERIPH);

    // status readback: remap flag in bit 0, other bits zero
    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[REMAP_BIT] = remapped;
    end
endmodule

// File: rtl/boot_remap_chk.sv
// boot_remap_chk: port-level properties of the remap decoder, bound to the top.
module boot_remap_chk #(
    parameter int ADDR_W       = 32,
    parameter int CTL_W        = 8,
    parameter bit AUTO_TRIGGER = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              ctl_wr,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              sel_rom,
    input logic              sel_ram,
    input logic              sel_periph,
    input logic              map_err
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_ram, sel_periph, map_err})); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |-> !(sel_rom || sel_ram || sel_periph || map_err)); // R12
    AST_STICKY_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[0] |=> ctl_rdata[0]); // R5
    AST_REMAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[0]) |-> ($past(ctl_wr && ctl_wdata[0]) ||
                                 (AUTO_TRIGGER && $past(bus_wr)))); // R4
    AST_WRITE_NOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !sel_rom); // R11
    AST_HIGH_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[31:16] == 16'hE000) |-> sel_rom); // R3
    AST_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1:1] == '0); // R1
endmodule

bind boot_remap_decoder boot_remap_chk #(
    .ADDR_W(ADDR_W), .CTL_W(CTL_W), .AUTO_TRIGGER(AUTO_TRIGGER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sel_rom(sel_rom), .sel_ram(sel_ram),
    .sel_periph(sel_periph), .map_err(map_err)
);

// File: tb/sim_boot_remap_decoder.sv
// Directed bench: u0 is the explicit-trigger build, u1 the automatic build.
module sim_boot_remap_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic        bus_rd, bus_wr, ctl_wr;
    logic [7:0]  ctl_wdata;
    logic [7:0]  rd0, rd1;
    logic        rom0, ram0, per0, err0, rom1, ram1, per1, err1;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_remap_decoder #(.AUTO_TRIGGER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(rd0), .sel_rom(rom0), .sel_ram(ram0),
        .sel_periph(per0), .map_err(err0));

    boot_remap_decoder #(.AUTO_TRIGGER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(rd1), .sel_rom(rom1), .sel_ram(ram1),
        .sel_periph(per1), .map_err(err1));

    // outcome codes packed as {rom, ram, periph, err}
    localparam logic [3:0] O_ROM = 4'b1000, O_RAM = 4'b0100,
                           O_PER = 4'b0010, O_ERR = 4'b0001, O_NONE = 4'b0000;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; ctl_wr = 0;
        ctl_wdata = 0; bus_addr = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one bus access at a negedge, sample both builds 1 ns later
    task automatic bus_op(input logic [31:0] a, input logic wr,
                          output logic [3:0] o0, output logic [3:0] o1);
        @(negedge clk);
        bus_addr = a; bus_rd = !wr; bus_wr = wr;
        #1;
        o0 = {rom0, ram0, per0, err0};
        o1 = {rom1, ram1, per1, err1};
    endtask

    task automatic bus_idle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 0;
    endtask

    task automatic t_reset();
        logic [3:0] o0, o1;
        do_reset();
        #1;
        check("R1 status after reset", rd0, 8'h00);
        check("R1 status after reset auto", rd1, 8'h00);
        check("R12 idle no select", {4'b0, rom0, ram0, per0, err0}, {4'b0, O_NONE});
        bus_op(32'h0, 1'b0, o0, o1); bus_idle();
        check("R2 boot read 0x0", {4'b0, o0}, {4'b0, O_ROM});
    endtask

    task automatic t_boot_reads();
        logic [3:0] o0, o1;
        do_reset();
        bus_op(32'h0000_001C, 1'b0, o0, o1);
        check("R2 boot read vector 0x1C", {4'b0, o0}, {4'b0, O_ROM});
        bus_op(32'h1234_5678, 1'b0, o0, o1);
        check("R2 boot read alias far", {4'b0, o0}, {4'b0, O_ROM});
        bus_op(32'hE000_0100, 1'b0, o0, o1);
        check("R3 boot read high ROM", {4'b0, o0}, {4'b0, O_ROM});
        bus_op(32'h8000_0004, 1'b0, o0, o1);
        check("R10 boot read periph", {4'b0, o0}, {4'b0, O_PER});
        bus_idle();
    endtask

    task automatic t_boot_writes();
        logic [3:0] o0, o1;
        do_reset();
        bus_op(32'h0000_0000, 1'b1, o0, o1);
        check("R8 boot write low region", {4'b0, o0}, {4'b0, O_ERR});
        bus_op(32'h8000_0000, 1'b1, o0, o1);
        check("R10 boot write periph", {4'b0, o0}, {4'b0, O_PER});
        bus_op(32'hE000_0000, 1'b1, o0, o1);
        check("R11 boot write ROM window", {4'b0, o0}, {4'b0, O_ERR});
        bus_idle(); #1;
        check("R8 no remap after write", rd0, 8'h00);
    endtask

    task automatic t_manual_remap();
        logic [3:0] o0, o1;
        do_reset();
        ctl_write(8'h00); #1;
        check("R4 zero write no remap", rd0, 8'h00);
        ctl_write(8'h01); #1;
        check("R4 remap bit set", rd0, 8'h01);
        bus_op(32'h0000_001C, 1'b0, o0, o1);
        check("R6 read vector from RAM", {4'b0, o0}, {4'b0, O_RAM});
        bus_op(32'h0000_0000, 1'b1, o0, o1);
        check("R6 write vector to RAM", {4'b0, o0}, {4'b0, O_RAM});
        bus_op(32'h000F_FFFC, 1'b0, o0, o1);
        check("R6 last RAM word", {4'b0, o0}, {4'b0, O_RAM});
        bus_op(32'h0010_0000, 1'b0, o0, o1);
        check("R7 past RAM end", {4'b0, o0}, {4'b0, O_ERR});
        bus_op(32'hE000_0010, 1'b0, o0, o1);
        check("R3 high ROM after remap", {4'b0, o0}, {4'b0, O_ROM});
        bus_op(32'hE001_0000, 1'b0, o0, o1);
        check("R7 past ROM window", {4'b0, o0}, {4'b0, O_ERR});
        bus_op(32'h1234_5678, 1'b0, o0, o1);
        check("R7 unmapped", {4'b0, o0}, {4'b0, O_ERR});
        bus_op(32'hE000_0000, 1'b1, o0, o1);
        check("R11 write ROM after remap", {4'b0, o0}, {4'b0, O_ERR});
        bus_op(32'h8000_FFFC, 1'b1, o0, o1);
        check("R10 periph after remap", {4'b0, o0}, {4'b0, O_PER});
        bus_idle();
        ctl_write(8'h00); #1;
        check("R5 sticky after zero write", rd0, 8'h01);
        do_reset(); #1;
        check("R5 reset clears remap", rd0, 8'h00);
    endtask

    task automatic t_auto();
        logic [3:0] o0, o1;
        do_reset();
        bus_op(32'h0, 1'b0, o0, o1);
        check("R9 auto build boot read ROM", {4'b0, o1}, {4'b0, O_ROM});
        bus_op(32'h0, 1'b1, o0, o1);
        check("R9 trigger write goes to RAM", {4'b0, o1}, {4'b0, O_RAM});
        check("R8 manual build same write errs", {4'b0, o0}, {4'b0, O_ERR});
        bus_idle(); #1;
        check("R9 auto status set", rd1, 8'h01);
        check("R8 manual status still boot", rd0, 8'h00);
        bus_op(32'h0, 1'b0, o0, o1);
        check("R9 auto read now RAM", {4'b0, o1}, {4'b0, O_RAM});
        bus_idle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; ctl_wr = 0;
        ctl_wdata = 0; bus_addr = 0;
        t_reset();
        t_boot_reads();
        t_boot_writes();
        t_manual_remap();
        t_auto();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule